// File: doc/BRIEF.md
# Host-to-CPU Terminal Mailbox

This block sits between a host byte stream and the I/O bus of an 8-bit processor. The host sends two-byte commands on a byte-wide input qualified by a valid strobe. A load command places one byte into a single-slot inbound mailbox. A status command asks for the number of bytes waiting, and the block answers on a byte-wide output. Any byte the processor writes on its bus is also forwarded to the host on that output.

On the processor side the block offers two readable locations. A select line chooses between them. An active-low enable frames each bus cycle, and a direction line marks it as a read or a write. Reading the mailbox location consumes the byte: it returns the byte and empties the slot. The control lines are asynchronous to the block clock, so they are synchronised first, and each bus cycle acts once, on the falling edge of the enable.

Top module: `term_mailbox`

## Requirements
- R1: After reset, `host_out_valid` and `bus_oe` are low and the waiting count reads as 0.
- R2: Host command byte 0x00 followed by a data byte stores that byte in the mailbox and sets the waiting count to 1, in the clock edge that takes the data byte.
- R3: A second load replaces the stored byte and does not add to it: the count stays 1 and the newest byte is the one read back.
- R4: Host command byte 0x01 answers with the current waiting count on `host_out_data`. `host_out_valid` is high for one cycle, right after the edge that takes the command.
- R5: A processor read with `bus_rs` = 0 returns the stored mailbox byte on `bus_dout`.
- R6: A processor read with `bus_rs` = 1 returns the waiting count, zero-extended, and leaves the byte and the count unchanged.
- R7: A processor read with `bus_rs` = 0 clears the stored byte to 0x00 and the count to 0.
- R8: `bus_oe` rises only for a read cycle (`bus_rw` = 1), three clock edges after `bus_en_n` falls. It drops three edges after `bus_en_n` rises, and it stays low for write cycles.
- R9: A processor write (`bus_rw` = 0) forwards `bus_din` to `host_out_data` with a one-cycle `host_out_valid` pulse, three edges after `bus_en_n` falls.
- R10: The enable, direction and select lines each pass through two synchronising flops. A bus cycle acts exactly once, however long `bus_en_n` stays low.
- R11: A host command byte other than 0x00 and 0x01 is dropped, and the next host byte is taken as a command again.
- R12: If a status answer and a processor write fall in the same cycle, the written byte goes out first and the count follows in the next cycle.
- R13: If a host data byte lands in the same edge as a processor mailbox read, the read returns the old byte. The new byte then stays in the mailbox with a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_in_data | input | 8 | Byte from the host |
| host_in_valid | input | 1 | Marks `host_in_data` as valid for one cycle |
| host_out_data | output | 8 | Status answer or processor-written byte |
| host_out_valid | output | 1 | One-cycle strobe for `host_out_data` |
| bus_en_n | input | 1 | Active-low bus cycle enable (asynchronous) |
| bus_rw | input | 1 | 1 = processor reads, 0 = processor writes |
| bus_rs | input | 1 | 0 = mailbox byte, 1 = waiting count |
| bus_din | input | 8 | Data driven by the processor |
| bus_dout | output | 8 | Data returned to the processor |
| bus_oe | output | 1 | Drive enable for `bus_dout` |

## Verification
Host-side results take effect in the edge that takes the host byte, so the bench checks them at the falling clock edge right after that edge. Bus-side results appear three rising edges after the enable changes: two synchroniser stages, then the registered action. The bench waits exactly three falling edges after it moves `bus_en_n` before it samples `bus_dout`, `bus_oe` or the forwarded byte. The collision tests place the host byte on that third edge, so both actions meet in one cycle.

// File: rtl/tm_pkg.sv
package tm_pkg;
    localparam logic [7:0] CMD_LOAD  = 8'h00;
    localparam logic [7:0] CMD_QUERY = 8'h01;

    typedef enum logic {
        PS_CMD  = 1'b0,
        PS_DATA = 1'b1
    } parse_st_e;
endpackage

// File: rtl/tm_sync.sv
module tm_sync #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    logic [N-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q[s] <= RST_VAL;
            end else if (s == 0) begin
                chain_q[s] <= async_i;
            end else begin
                chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/tm_host_parser.sv
module tm_host_parser
    import tm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] in_data,
    input  logic          in_valid,
    output logic          load_o,
    output logic [DW-1:0] load_byte_o,
    output logic          query_o
);
    typedef struct packed {
        parse_st_e st;
    } pstate_t;

    pstate_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        load_o  = 1'b0;
        query_o = 1'b0;
        if (in_valid) begin
            if (s_q.st == PS_DATA) begin
                load_o = 1'b1;
                s_d.st = PS_CMD;
            end else if (in_data == DW'(CMD_LOAD)) begin
                s_d.st = PS_DATA;
            end else if (in_data == DW'(CMD_QUERY)) begin
                query_o = 1'b1;
            end
        end
    end

    assign load_byte_o = in_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: PS_CMD};
        else        s_q <= s_d;
    end

    // R11: an unknown command leaves the parser waiting for a command
    p_bad_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && s_q.st == PS_CMD && in_data != DW'(CMD_LOAD) && in_data != DW'(CMD_QUERY))
        |=> (s_q.st == PS_CMD));

    // R2: a load command arms the data phase
    p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && s_q.st == PS_CMD && in_data == DW'(CMD_LOAD)) |=> (s_q.st == PS_DATA));
endmodule

// File: rtl/tm_core.sv
module tm_core #(
    parameter int DW    = 8,
    parameter int CNT_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_n_s,
    input  logic          rw_s,
    input  logic          rs_s,
    input  logic [DW-1:0] bus_din,
    input  logic          load,
    input  logic [DW-1:0] load_byte,
    input  logic          query,
    output logic [DW-1:0] bus_dout,
    output logic          bus_oe,
    output logic [DW-1:0] out_data,
    output logic          out_valid
);
    typedef struct packed {
        logic [DW-1:0]    data;
        logic [CNT_W-1:0] cnt;
        logic [DW-1:0]    rd;
        logic             oe;
        logic [DW-1:0]    odat;
        logic             ovld;
        logic             pend;
        logic             en_prev;
    } core_t;

    core_t c_d, c_q;
    logic  act, rd_stb, wr_stb;

    assign act    = c_q.en_prev && !en_n_s;
    assign rd_stb = act && rw_s;
    assign wr_stb = act && !rw_s;

    always_comb begin
        c_d         = c_q;
        c_d.en_prev = en_n_s;
        c_d.ovld    = 1'b0;

        if (rd_stb) begin
            c_d.rd = rs_s ? DW'(c_q.cnt) : c_q.data;
            c_d.oe = 1'b1;
            if (!rs_s) begin
                c_d.data = '0;
                c_d.cnt  = '0;
            end
        end else if (en_n_s) begin
            c_d.oe = 1'b0;
        end

        if (load) begin
            c_d.data = load_byte;
            c_d.cnt  = CNT_W'(1);
        end

        if (wr_stb) begin
            c_d.odat = bus_din;
            c_d.ovld = 1'b1;
            c_d.pend = c_q.pend | query;
        end else if (query || c_q.pend) begin
            c_d.odat = DW'(c_q.cnt);
            c_d.ovld = 1'b1;
            c_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q         <= '0;
            c_q.en_prev <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign bus_dout  = c_q.rd;
    assign bus_oe    = c_q.oe;
    assign out_data  = c_q.odat;
    assign out_valid = c_q.ovld;

    // R2: a load from the parser leaves the byte stored and count at one
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (c_q.data == $past(load_byte) && c_q.cnt == CNT_W'(1)));

    // R7: a mailbox read with no concurrent load empties the slot
    p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !rs_s && !load) |=> (c_q.cnt == '0 && c_q.data == '0));

    // R8: the bus is driven only after a synchronised low enable
    p_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !$past(en_n_s));

    // R9: a processor write reaches the host output in the next cycle
    p_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (out_valid && out_data == $past(bus_din)));

    // R10: a bus action never fires on two consecutive cycles
    p_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> !act);

    // R12: a colliding status answer is held back one cycle
    p_defer_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && query) |=> ##1 (out_valid && !c_q.pend));
endmodule

// File: rtl/term_mailbox.sv
module term_mailbox #(
    parameter int DW          = 8,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] host_in_data,
    input  logic          host_in_valid,
    output logic [DW-1:0] host_out_data,
    output logic          host_out_valid,
    input  logic          bus_en_n,
    input  logic          bus_rw,
    input  logic          bus_rs,
    input  logic [DW-1:0] bus_din,
    output logic [DW-1:0] bus_dout,
    output logic          bus_oe
);
    localparam int NCTL = 3;

    logic [NCTL-1:0] ctl_s;
    logic            load, query;
    logic [DW-1:0]   load_byte;

    tm_sync #(
        .N       (NCTL),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({bus_en_n, bus_rw, bus_rs}),
        .sync_o  (ctl_s)
    );

    tm_host_parser #(.DW(DW)) i_parser (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_data     (host_in_data),
        .in_valid    (host_in_valid),
        .load_o      (load),
        .load_byte_o (load_byte),
        .query_o     (query)
    );

    tm_core #(.DW(DW), .CNT_W(CNT_W)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_n_s    (ctl_s[2]),
        .rw_s      (ctl_s[1]),
        .rs_s      (ctl_s[0]),
        .bus_din   (bus_din),
        .load      (load),
        .load_byte (load_byte),
        .query     (query),
        .bus_dout  (bus_dout),
        .bus_oe    (bus_oe),
        .out_data  (host_out_data),
        .out_valid (host_out_valid)
    );
endmodule

// File: tb/test_term_mailbox.sv
`timescale 1ns/1ps
module test_term_mailbox;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] h_in = 8'h00;
    logic       h_vld = 1'b0;
    logic [7:0] host_out_data;
    logic       host_out_valid;
    logic       en_n = 1'b1, rw_i = 1'b0, rs_i = 1'b0;
    logic [7:0] din_i = 8'h00;
    logic [7:0] bus_dout;
    logic       bus_oe;

    int checks = 0, errors = 0, pulses = 0, cycles = 0;

    always #2.5 clk = ~clk;

    term_mailbox i_term_mailbox (
        .clk(clk), .rst_n(rst_n),
        .host_in_data(h_in), .host_in_valid(h_vld),
        .host_out_data(host_out_data), .host_out_valid(host_out_valid),
        .bus_en_n(en_n), .bus_rw(rw_i), .bus_rs(rs_i), .bus_din(din_i),
        .bus_dout(bus_dout), .bus_oe(bus_oe)
    );

    always @(negedge clk) if (host_out_valid) pulses++;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: act=%0d exp<=100000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic host_send(input logic [7:0] b, output logic vld, output logic [7:0] dat);
        @(negedge clk); h_vld = 1'b1; h_in = b;
        @(negedge clk); h_vld = 1'b0;
        vld = host_out_valid; dat = host_out_data;
    endtask

    task automatic cpu_cycle(input logic rw, input logic rs, input logic [7:0] din, input int hold,
                             output logic [7:0] dout, output logic oe, output logic vld,
                             output logic [7:0] hout, output logic oe_after);
        @(negedge clk); en_n = 1'b0; rw_i = rw; rs_i = rs; din_i = din;
        repeat (3) @(negedge clk);
        dout = bus_dout; oe = bus_oe; vld = host_out_valid; hout = host_out_data;
        repeat (hold) @(negedge clk);
        en_n = 1'b1;
        repeat (3) @(negedge clk);
        oe_after = bus_oe;
    endtask

    // vector: op[17:16] arg[15:8] exp[7:0]; op 0=host byte, 1=status query, 2=read (arg[0]=rs), 3=write
    localparam int NV = 22;
    localparam logic [17:0] VEC [NV] = '{
        {2'd0, 8'h00, 8'h00}, {2'd0, 8'h5A, 8'h00}, {2'd1, 8'h01, 8'h01},
        {2'd2, 8'h01, 8'h01}, {2'd2, 8'h00, 8'h5A}, {2'd2, 8'h01, 8'h00},
        {2'd1, 8'h01, 8'h00}, {2'd2, 8'h00, 8'h00},
        {2'd0, 8'h00, 8'h00}, {2'd0, 8'h11, 8'h00}, {2'd0, 8'h00, 8'h00},
        {2'd0, 8'h22, 8'h00}, {2'd2, 8'h01, 8'h01}, {2'd2, 8'h00, 8'h22},
        {2'd3, 8'hA5, 8'hA5}, {2'd0, 8'h09, 8'h00}, {2'd1, 8'h01, 8'h00},
        {2'd0, 8'hFF, 8'h00}, {2'd0, 8'h00, 8'h00}, {2'd0, 8'h33, 8'h00},
        {2'd1, 8'h01, 8'h01}, {2'd2, 8'h00, 8'h33}
    };

    initial begin
        logic       v, oe, oe_after;
        logic [7:0] d, dout;

        repeat (3) @(negedge clk);
        check("R1 out_valid", {7'd0, host_out_valid}, 8'h00);
        check("R1 bus_oe", {7'd0, bus_oe}, 8'h00);
        rst_n = 1'b1;
        cpu_cycle(1'b1, 1'b1, 8'h00, 0, dout, oe, v, d, oe_after);
        check("R1 count after reset", dout, 8'h00);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][17:16])
                2'd0: host_send(VEC[i][15:8], v, d);
                2'd1: begin
                    host_send(VEC[i][15:8], v, d);
                    check("R4/R11 reply valid", {7'd0, v}, 8'h01);
                    check("R4/R11 reply count", d, VEC[i][7:0]);
                end
                2'd2: begin
                    cpu_cycle(1'b1, VEC[i][8], 8'h00, 0, dout, oe, v, d, oe_after);
                    check(VEC[i][8] ? "R6 count read" : "R5/R7/R3 data read", dout, VEC[i][7:0]);
                    check("R8 oe on read", {7'd0, oe}, 8'h01);
                    check("R8 oe released", {7'd0, oe_after}, 8'h00);
                end
                default: begin
                    cpu_cycle(1'b0, 1'b0, VEC[i][15:8], 0, dout, oe, v, d, oe_after);
                    check("R9 forward valid", {7'd0, v}, 8'h01);
                    check("R9 forward data", d, VEC[i][7:0]);
                    check("R8 no oe on write", {7'd0, oe}, 8'h00);
                end
            endcase
        end

        // R10: long enable-low write gives exactly one pulse
        repeat (2) @(negedge clk);
        pulses = 0;
        cpu_cycle(1'b0, 1'b0, 8'h6C, 8, dout, oe, v, d, oe_after);
        repeat (2) @(negedge clk);
        check("R10 single action", 8'(pulses), 8'h01);

        // R12: processor write and status query in the same cycle; count is 0 now
        @(negedge clk); en_n = 1'b0; rw_i = 1'b0; din_i = 8'hC3;
        repeat (2) @(negedge clk);
        h_vld = 1'b1; h_in = 8'h01;
        @(negedge clk); h_vld = 1'b0;
        check("R12 first is written byte", host_out_data, 8'hC3);
        check("R12 first valid", {7'd0, host_out_valid}, 8'h01);
        @(negedge clk);
        check("R12 count follows", host_out_data, 8'h00);
        check("R12 second valid", {7'd0, host_out_valid}, 8'h01);
        en_n = 1'b1;
        repeat (4) @(negedge clk);

        // R13: host data byte lands with a mailbox read
        host_send(8'h00, v, d);
        host_send(8'h10, v, d);
        host_send(8'h00, v, d);
        @(negedge clk); en_n = 1'b0; rw_i = 1'b1; rs_i = 1'b0;
        repeat (2) @(negedge clk);
        h_vld = 1'b1; h_in = 8'h77;
        @(negedge clk); h_vld = 1'b0;
        check("R13 read returns old byte", bus_dout, 8'h10);
        en_n = 1'b1;
        repeat (4) @(negedge clk);
        cpu_cycle(1'b1, 1'b1, 8'h00, 0, dout, oe, v, d, oe_after);
        check("R13 count kept", dout, 8'h01);
        cpu_cycle(1'b1, 1'b0, 8'h00, 0, dout, oe, v, d, oe_after);
        check("R13 new byte kept", dout, 8'h77);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule